// File: doc/BRIEF.md
# Masked Interrupt Controller

This block collects up to 32 interrupt lines and turns them into one interrupt request for the processor core. Each line has a status bit. A rising edge on the line latches that bit, and it stays set until software clears it. A mask register chooses which latched sources may reach the core. The request output is high whenever at least one status bit is set and its mask bit is also set.

Software reaches both registers through a special-register access port. The address is formed as `(group << 11) + index`, and both registers sit in group 9. The mask is at index 0 and the status is at index 2. A write to the mask replaces it. A write to the status uses write-one-to-clear: each 1 in the write data clears that status bit, and each 0 leaves its bit unchanged. Reads return the current contents of the addressed register through a combinational path.

The request is a registered output. It is computed from the register values being loaded at the same clock edge. A write to either register, or a new edge on a line, is therefore visible on the request output at the same edge that updates the register.

Top module: `masked_irq_ctrl`

## Requirements
- R1: After reset the mask and status registers both read 0, and the request output is 0.
- R2: A write to address 0x4800 (group 9, index 0) loads the write data into the mask at the next clock edge. A later read of 0x4800 returns that value.
- R3: A write to address 0x4802 (group 9, index 2) clears every status bit whose write-data bit is 1 and keeps every bit whose write-data bit is 0. A read of 0x4802 returns the status.
- R4: When bit i of the interrupt lines is low at one clock edge and high at the next, status bit i is set at that second edge. A line that stays high after its bit has been cleared does not set the bit again.
- R5: If a rising edge and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R6: The request output equals the OR of (status AND mask), using the register contents after each clock edge. A mask or status change therefore reaches the request at the same edge.
- R7: A write to any address other than 0x4800 or 0x4802 changes neither register. A read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sprAddr | input | 16 | Special-register address for the read or write |
| sprWe | input | 1 | Write strobe, sampled at the rising clock edge |
| sprWrData | input | 32 | Write data |
| sprRdData | output | 32 | Contents of the addressed register (combinational) |
| irqLines | input | 32 | Incoming interrupt lines; a rising edge latches one |
| irqReq | output | 1 | Registered interrupt request to the core |

## Verification
A rising edge on a line and a write-one-to-clear to the status register can land on the same bit in the same cycle. The set must win. The bench provokes this in two ways: in a directed step it lowers a line and then raises it in the very cycle that clears its bit, and in the random phase it toggles lines while writing status with random data. A reference model in the bench applies the clear first and the set after it, then compares both the status read-back and the request output after every edge. A mask write that coincides with a new edge is also judged, because the request must reflect both changes at the same edge.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
  localparam int GROUP_SHIFT = 11;
  localparam int IRQ_GROUP   = 9;
  localparam int MASK_INDEX  = 0;
  localparam int STAT_INDEX  = 2;

  localparam logic [15:0] MASK_ADDR = 16'((IRQ_GROUP << GROUP_SHIFT) + MASK_INDEX);
  localparam logic [15:0] STAT_ADDR = 16'((IRQ_GROUP << GROUP_SHIFT) + STAT_INDEX);

  typedef struct packed {
    logic wrMask;
    logic wrStatus;
    logic selMask;
    logic selStatus;
  } mirq_strobe_t;
endpackage

// File: rtl/mirq_ctrl.sv
module mirq_ctrl
  import mirq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] sprAddr,
  input  logic              sprWe,
  output mirq_strobe_t      strb
);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic hitMask;
  logic hitStatus;

  assign hitMask   = (sprAddr == MASK_A);
  assign hitStatus = (sprAddr == STAT_A);

  always_comb begin
    strb.selMask   = hitMask;
    strb.selStatus = hitStatus;
    strb.wrMask    = sprWe & hitMask;
    strb.wrStatus  = sprWe & hitStatus;
  end
endmodule

// File: rtl/mirq_datapath.sv
module mirq_datapath
  import mirq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  mirq_strobe_t       strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] irqLines,
  output logic [NUM_SRC-1:0] maskVal,
  output logic [NUM_SRC-1:0] statusVal,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqReq
);
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] prevLines;
  logic [NUM_SRC-1:0] maskNext;
  logic [NUM_SRC-1:0] statusNext;
  logic [NUM_SRC-1:0] riseBit;
  logic [NUM_SRC-1:0] clrBit;
  logic               irqQ;

  // Per-source latch: the set from an edge overrides a clear in the same cycle
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign riseBit[i]    = irqLines[i] & ~prevLines[i];
    assign clrBit[i]     = strb.wrStatus & wrData[i];
    assign statusNext[i] = riseBit[i] | (statusQ[i] & ~clrBit[i]);
  end

  assign maskNext = strb.wrMask ? wrData[NUM_SRC-1:0] : maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ     <= '0;
      statusQ   <= '0;
      prevLines <= '0;
      irqQ      <= 1'b0;
    end else begin
      maskQ     <= maskNext;
      statusQ   <= statusNext;
      prevLines <= irqLines;
      irqQ      <= |(statusNext & maskNext);
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.selMask) begin
      rdData[NUM_SRC-1:0] = maskQ;
    end else if (strb.selStatus) begin
      rdData[NUM_SRC-1:0] = statusQ;
    end
  end

  assign maskVal   = maskQ;
  assign statusVal = statusQ;
  assign irqReq    = irqQ;
endmodule

// File: rtl/masked_irq_ctrl.sv
module masked_irq_ctrl
  import mirq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  sprAddr,
  input  logic               sprWe,
  input  logic [DATA_W-1:0]  sprWrData,
  output logic [DATA_W-1:0]  sprRdData,
  input  logic [NUM_SRC-1:0] irqLines,
  output logic               irqReq
);
  mirq_strobe_t       strb;
  logic [NUM_SRC-1:0] maskVal;
  logic [NUM_SRC-1:0] statusVal;

  mirq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .sprAddr (sprAddr),
    .sprWe   (sprWe),
    .strb    (strb)
  );

  mirq_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (sprWrData),
    .irqLines  (irqLines),
    .maskVal   (maskVal),
    .statusVal (statusVal),
    .rdData    (sprRdData),
    .irqReq    (irqReq)
  );
endmodule

// File: rtl/masked_irq_ctrl_chk.sv
module masked_irq_ctrl_chk
  import mirq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  sprAddr,
  input logic               sprWe,
  input logic [DATA_W-1:0]  sprWrData,
  input logic [NUM_SRC-1:0] irqLines,
  input logic               irqReq,
  input logic [NUM_SRC-1:0] maskVal,
  input logic [NUM_SRC-1:0] statusVal
);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic [NUM_SRC-1:0] prevChk;
  logic [NUM_SRC-1:0] riseChk;
  logic               mWr;
  logic               sWr;

  always_ff @(posedge clk) begin
    if (!rstN) prevChk <= '0;
    else       prevChk <= irqLines;
  end

  assign riseChk = irqLines & ~prevChk;
  assign mWr     = sprWe && (sprAddr == MASK_A);
  assign sWr     = sprWe && (sprAddr == STAT_A);

  // R6
  irq_tracks_regs_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == |(statusVal & maskVal));

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    mWr |=> maskVal == $past(sprWrData[NUM_SRC-1:0]));

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mWr |=> $stable(maskVal));

  // R4
  rise_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (riseChk != '0) |=> ((statusVal & $past(riseChk)) == $past(riseChk)));

  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sWr && riseChk == '0) |=> statusVal == ($past(statusVal) & ~$past(sprWrData[NUM_SRC-1:0])));

  // R7
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sWr && riseChk == '0) |=> $stable(statusVal));
endmodule

bind masked_irq_ctrl masked_irq_ctrl_chk #(
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sprAddr   (sprAddr),
  .sprWe     (sprWe),
  .sprWrData (sprWrData),
  .irqLines  (irqLines),
  .irqReq    (irqReq),
  .maskVal   (maskVal),
  .statusVal (statusVal)
);

// File: tb/masked_irq_ctrl_tb.sv
module masked_irq_ctrl_tb;
  localparam int HALF = 10;
  localparam logic [15:0] A_MASK = 16'h4800;
  localparam logic [15:0] A_STAT = 16'h4802;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] sprAddr = '0;
  logic        sprWe = 1'b0;
  logic [31:0] sprWrData = '0;
  logic [31:0] sprRdData;
  logic [31:0] irqLines = '0;
  logic        irqReq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [31:0] mMask = '0;
  logic [31:0] mStat = '0;
  logic [31:0] mPrev = '0;

  always #HALF clk = ~clk;

  masked_irq_ctrl u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .sprAddr   (sprAddr),
    .sprWe     (sprWe),
    .sprWrData (sprWrData),
    .sprRdData (sprRdData),
    .irqLines  (irqLines),
    .irqReq    (irqReq)
  );

  function automatic logic [31:0] expRead(logic [15:0] a);
    if (a == A_MASK) return mMask;
    if (a == A_STAT) return mStat;
    return 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model, sample 1 ns after the edge
  task automatic step(logic we, logic [15:0] a, logic [31:0] d, logic [31:0] ln, string tag);
    logic [31:0] rise;
    logic [31:0] clr;
    @(negedge clk);
    sprWe = we; sprAddr = a; sprWrData = d; irqLines = ln;
    rise = ln & ~mPrev;
    clr  = (we && a == A_STAT) ? d : 32'h0;
    mStat = (mStat & ~clr) | rise;
    if (we && a == A_MASK) mMask = d;
    mPrev = ln;
    @(posedge clk);
    #1;
    check({tag, " read"}, sprRdData, expRead(a));
    check({tag, " irq"}, {31'h0, irqReq}, {31'h0, |(mStat & mMask)});
  endtask

  initial begin
    #(2 * HALF * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] ln;
    void'($urandom(32'd4242));
    // R1 reset state
    repeat (3) @(posedge clk);
    sprAddr = A_MASK; #1;
    check("R1 mask", sprRdData, 32'h0);
    sprAddr = A_STAT; #1;
    check("R1 status", sprRdData, 32'h0);
    check("R1 irq", {31'h0, irqReq}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    step(1'b1, A_MASK, 32'h0000_00F0, 32'h0, "R2");
    step(1'b0, A_STAT, 32'h0, 32'h0000_0010, "R4");
    step(1'b0, A_STAT, 32'h0, 32'h0000_0010, "R6");
    step(1'b1, A_MASK, 32'h0, 32'h0000_0010, "R6");
    step(1'b1, A_MASK, 32'h0000_0010, 32'h0000_0010, "R6");
    // clear while line stays high: must not relatch
    step(1'b1, A_STAT, 32'h0000_0010, 32'h0000_0010, "R3");
    step(1'b0, A_STAT, 32'h0, 32'h0000_0010, "R4");
    // set and clear in the same cycle: set wins
    step(1'b0, A_STAT, 32'h0, 32'h0, "R5");
    step(1'b1, A_STAT, 32'h0000_0010, 32'h0000_0010, "R5");
    // partial clear
    step(1'b0, A_STAT, 32'h0, 32'h0000_001F, "R4");
    step(1'b1, A_STAT, 32'h0000_0005, 32'h0000_001F, "R3");
    step(1'b1, A_MASK, 32'hFFFF_FFFF, 32'h0000_001F, "R2");
    // unmapped addresses
    step(1'b1, 16'h4801, 32'hFFFF_FFFF, 32'h0000_001F, "R7");
    step(1'b1, 16'h0002, 32'hFFFF_FFFF, 32'h0000_001F, "R7");
    step(1'b1, 16'h5000, 32'h0, 32'h0000_001F, "R7");
    step(1'b1, 16'h4803, 32'hFFFF_FFFF, 32'h0000_001F, "R7");
    step(1'b0, A_STAT, 32'h0, 32'h0000_001F, "R7");
    step(1'b0, A_MASK, 32'h0, 32'h0000_001F, "R7");

    // random phase, R6 and R5 collisions
    ln = 32'h0000_001F;
    for (int k = 0; k < 800; k++) begin
      logic [15:0] a;
      int sel;
      sel = int'($urandom % 4);
      a = (sel == 0) ? A_MASK : (sel == 3) ? 16'($urandom) : A_STAT;
      ln = ln ^ ($urandom & $urandom & $urandom);
      step(1'($urandom), a, $urandom, ln, "R6 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule